// File: doc/BRIEF.md
# Interrupt status summary controller

This block keeps one 32-bit status word of sticky event flags, a 32-bit enable word, and a single level interrupt line. Event pulses from the rest of the controller set their flags. Software clears flags by writing ones to the status word. Two summary flags are derived from the enabled events. The "normal" summary covers routine completions. The "abnormal" summary covers error and link conditions. Only these two summary flags, each gated by its own enable bit, can drive the interrupt line.

The summary flags are never stored. They are recomputed from the current event flags and enable word, so they follow every change to either word. The status word also carries a 9-bit engine-state field, which is taken straight from an input. Its top four reserved bits always read as one. A synchronous soft reset returns the block to its power-up values.

Top module: `int_summary_ctrl`

## Requirements
- R1: After reset `stat_rd` reads 0xF0000000 when `state_in` is zero, `mask_rd` reads 0xF3FE0000, and `irq` is low.
- R2: A one on `evt_set[i]` sets status bit i on the next clock for every event position (bits 0 to 14, 26 and 27). A one at any other position of `evt_set` leaves `stat_rd` unchanged.
- R3: A write with `wr_sel`=0 clears each event bit whose `wr_data` bit is one on the next clock. Event bits written with zero keep their value.
- R4: When a bit is both pulsed on `evt_set` and written with one in the same cycle, the bit ends up set.
- R5: Status bit 16 (normal summary) reads one exactly when any of status bits 0, 2, 6, 11 or 14 is set together with the same bit of the mask.
- R6: Status bit 15 (abnormal summary) reads one exactly when any of status bits 1, 3, 4, 5, 7, 8, 9, 10, 12, 13, 26 or 27 is set together with the same bit of the mask.
- R7: Writing a one to a summary bit does not clear it while an enabled event of its group remains set. The summary bits follow a mask change in the same cycle the new mask is visible.
- R8: `irq` equals, one clock later, (status bit 16 AND mask bit 16) OR (status bit 15 AND mask bit 15).
- R9: Status bits 25:17 always show `state_in`, and bits 31:28 always read one. Writing the status word or pulsing `evt_set` never alters these bits.
- R10: A write with `wr_sel`=1 replaces the whole mask with `wr_data` on the next clock.
- R11: A `soft_rst` cycle returns the event bits, the mask and `irq` to the R1 values on the next clock, taking priority over set pulses and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset |
| evt_set | input | 32 | Event set pulses, aligned to status bit positions |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status (write-one-to-clear), 1 mask |
| wr_data | input | 32 | Write data |
| state_in | input | 9 | Engine state shown in status bits 25:17 |
| stat_rd | output | 32 | Status word readback |
| mask_rd | output | 32 | Mask word readback |
| irq | output | 1 | Level interrupt request |

## Verification
Events are raised in only one group at a time, so the normal and abnormal summaries can each be shown to respond to their own members alone. The runs switch between a mask that enables an event but not its summary, and one that enables both. This separates summary computation from interrupt gating. Pulses at state and reserved positions, and status writes of all ones, show that only event bits can be touched. Collisions of set and clear on one bit, and clears aimed at a summary bit while its events remain, show the set-priority and recompute rules. A soft reset issued while events and writes are active checks its priority over both.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ABN_BIT = 15;
  localparam int unsigned NRM_BIT = 16;
  localparam int unsigned ST_LSB  = 17;
  localparam int unsigned ST_W    = 9;
  localparam int unsigned ST_MSB  = ST_LSB + ST_W - 1;

  // group members by status bit position
  localparam logic [WORD_W-1:0] NRM_SRC  = 32'h0000_4845;
  localparam logic [WORD_W-1:0] ABN_SRC  = 32'h0C00_37BA;
  localparam logic [WORD_W-1:0] EVT_BITS = NRM_SRC | ABN_SRC;
  localparam logic [WORD_W-1:0] RSV_ONES = 32'hF000_0000;
  localparam logic [WORD_W-1:0] MASK_RST = 32'hF3FE_0000;

  function automatic logic group_hit(input logic [WORD_W-1:0] ev,
                                     input logic [WORD_W-1:0] en,
                                     input logic [WORD_W-1:0] grp);
    return |(ev & en & grp);
  endfunction

  function automatic logic [WORD_W-1:0] compose(input logic [WORD_W-1:0] ev,
                                                input logic nrm,
                                                input logic abn,
                                                input logic [ST_W-1:0] st);
    logic [WORD_W-1:0] w;
    w = RSV_ONES | (ev & EVT_BITS);
    w[NRM_BIT] = nrm;
    w[ABN_BIT] = abn;
    w[ST_MSB:ST_LSB] = st;
    return w;
  endfunction
endpackage

// File: rtl/isc_event_bank.sv
module isc_event_bank
  import isc_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] ev_q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (EVT_BITS[g]) begin : g_flop
      logic b_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          b_q <= 1'b0;
        else if (soft_rst)   b_q <= 1'b0;
        else if (set_i[g])   b_q <= 1'b1;
        else if (clr_i[g])   b_q <= 1'b0;
      end
      assign ev_q[g] = b_q;
    end else begin : g_tie
      assign ev_q[g] = 1'b0;
    end
  end

  logic [W-1:0] set_ev;
  logic [W-1:0] clr_only;
  logic         quiet;
  assign set_ev   = set_i & EVT_BITS;
  assign clr_only = clr_i & ~set_i & EVT_BITS;
  assign quiet    = ~|set_ev & ~|clr_only;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((ev_q & $past(set_ev)) == $past(set_ev))); // R4
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((ev_q & $past(clr_only)) == '0)); // R3
  AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && quiet) |=> $stable(ev_q)); // R3
  AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_q & ~EVT_BITS) == '0)); // R2
endmodule

// File: rtl/isc_summary.sv
module isc_summary
  import isc_pkg::*;
(
  input  logic [WORD_W-1:0] ev,
  input  logic [WORD_W-1:0] en,
  output logic              nrm,
  output logic              abn
);
  always_comb begin
    nrm = group_hit(ev, en, NRM_SRC);
    abn = group_hit(ev, en, ABN_SRC);
  end
endmodule

// File: rtl/isc_irq_reg.sv
module isc_irq_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic nrm,
  input  logic abn,
  input  logic nrm_en,
  input  logic abn_en,
  output logic irq
);
  logic req;
  assign req = (nrm & nrm_en) | (abn & abn_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq <= 1'b0;
    else if (soft_rst) irq <= 1'b0;
    else               irq <= req;
  end
endmodule

// File: rtl/int_summary_ctrl.sv
module int_summary_ctrl
  import isc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [WORD_W-1:0] evt_set,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ST_W-1:0]   state_in,
  output logic [WORD_W-1:0] stat_rd,
  output logic [WORD_W-1:0] mask_rd,
  output logic              irq
);
  logic [WORD_W-1:0] mask_q;
  logic [WORD_W-1:0] ev_q;
  logic [WORD_W-1:0] clr_vec;
  logic              mask_wr;
  logic              nrm_sum;
  logic              abn_sum;

  assign clr_vec = (wr_en && !wr_sel) ? wr_data : '0;
  assign mask_wr = wr_en && wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= MASK_RST;
    else if (soft_rst) mask_q <= MASK_RST;
    else if (mask_wr)  mask_q <= wr_data;
  end

  isc_event_bank #(.W(WORD_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .set_i(evt_set), .clr_i(clr_vec), .ev_q(ev_q)
  );

  isc_summary u_sum (
    .ev(ev_q), .en(mask_q), .nrm(nrm_sum), .abn(abn_sum)
  );

  isc_irq_reg u_irq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .nrm(nrm_sum), .abn(abn_sum),
    .nrm_en(mask_q[NRM_BIT]), .abn_en(mask_q[ABN_BIT]),
    .irq(irq)
  );

  assign stat_rd = compose(ev_q, nrm_sum, abn_sum, state_in);
  assign mask_rd = mask_q;

  AST_NRM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd[NRM_BIT] == (|(stat_rd & mask_rd & NRM_SRC))); // R5
  AST_ABN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd[ABN_BIT] == (|(stat_rd & mask_rd & ABN_SRC))); // R6
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> irq == $past((stat_rd[NRM_BIT] & mask_rd[NRM_BIT]) |
                               (stat_rd[ABN_BIT] & mask_rd[ABN_BIT]))); // R8
  AST_STATE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd[ST_MSB:ST_LSB] == state_in) && (stat_rd[31:28] == 4'hF)); // R9
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !soft_rst) |=> mask_rd == $past(wr_data)); // R10
  AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mask_rd == MASK_RST) && !irq && ((stat_rd & EVT_BITS) == '0)); // R11
endmodule

// File: tb/sim_int_summary_ctrl.sv
module sim_int_summary_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [31:0] evt_set = '0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [8:0]  state_in = '0;
  logic [31:0] stat_rd;
  logic [31:0] mask_rd;
  logic        irq;

  always #5 clk = ~clk;

  int_summary_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt_set(evt_set),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .state_in(state_in),
    .stat_rd(stat_rd), .mask_rd(mask_rd), .irq(irq)
  );

  typedef struct {
    string       tag;
    logic [31:0] stat;
    logic [31:0] mask;
    logic        irq;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // reference model state
  localparam int NRM_LIST[5]  = '{0, 2, 6, 11, 14};
  localparam int ABN_LIST[12] = '{1, 3, 4, 5, 7, 8, 9, 10, 12, 13, 26, 27};
  logic [31:0] m_ev   = '0;
  logic [31:0] m_mask = 32'hF3FE_0000;

  function automatic logic is_event(input int i);
    foreach (NRM_LIST[k]) if (NRM_LIST[k] == i) return 1'b1;
    foreach (ABN_LIST[k]) if (ABN_LIST[k] == i) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic sum_nrm(input logic [31:0] ev, input logic [31:0] mk);
    logic r = 1'b0;
    foreach (NRM_LIST[k]) r = r | (ev[NRM_LIST[k]] & mk[NRM_LIST[k]]);
    return r;
  endfunction

  function automatic logic sum_abn(input logic [31:0] ev, input logic [31:0] mk);
    logic r = 1'b0;
    foreach (ABN_LIST[k]) r = r | (ev[ABN_LIST[k]] & mk[ABN_LIST[k]]);
    return r;
  endfunction

  function automatic logic [31:0] view(input logic [31:0] ev, input logic [31:0] mk,
                                       input logic [8:0] st);
    logic [31:0] v;
    v = ev;
    v[16] = sum_nrm(ev, mk);
    v[15] = sum_abn(ev, mk);
    v[25:17] = st;
    v[31:28] = 4'hF;
    return v;
  endfunction

  // driver: applies one cycle of stimulus and queues what must follow it
  task automatic step(input string tag, input logic [31:0] set, input logic we,
                      input logic sel, input logic [31:0] d, input logic sr,
                      input logic [8:0] st);
    exp_t e;
    logic [31:0] n_ev, n_mask;
    logic        n_irq;
    @(negedge clk);
    evt_set = set; wr_en = we; wr_sel = sel; wr_data = d;
    soft_rst = sr; state_in = st;
    if (sr) begin
      n_ev = '0; n_mask = 32'hF3FE_0000; n_irq = 1'b0;
    end else begin
      n_irq = (sum_nrm(m_ev, m_mask) & m_mask[16]) |
              (sum_abn(m_ev, m_mask) & m_mask[15]);
      n_ev = m_ev;
      for (int i = 0; i < 32; i++) begin
        if (is_event(i)) begin
          if (set[i])                n_ev[i] = 1'b1;
          else if (we && !sel && d[i]) n_ev[i] = 1'b0;
        end
      end
      n_mask = (we && sel) ? d : m_mask;
    end
    m_ev = n_ev; m_mask = n_mask;
    e.tag = tag; e.stat = view(n_ev, n_mask, st); e.mask = n_mask; e.irq = n_irq;
    q.push_back(e);
  endtask

  task automatic idle(input string tag, input logic [8:0] st);
    step(tag, '0, 1'b0, 1'b0, '0, 1'b0, st);
  endtask

  // monitor: compares after every active edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (stat_rd !== e.stat || mask_rd !== e.mask || irq !== e.irq) begin
          n_bad++;
          $display("FAIL %s: stat=%h mask=%h irq=%b expected stat=%h mask=%h irq=%b",
                   e.tag, stat_rd, mask_rd, irq, e.stat, e.mask, e.irq);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #22;
    rst_n = 1'b1;
    n_chk++; // R1 reset values
    if (stat_rd !== 32'hF000_0000 || mask_rd !== 32'hF3FE_0000 || irq !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: stat=%h mask=%h irq=%b expected stat=f0000000 mask=f3fe0000 irq=0",
               stat_rd, mask_rd, irq);
    end
    // R2: set transmit-complete style bit 0 with summary disabled
    step("R2", 32'h0000_0001, 0, 0, '0, 0, '0);
    // R2 / R9: pulses at state, reserved and summary positions are ignored
    step("R9", 32'hF3FF_8000, 0, 0, '0, 0, '0);
    idle("R2", '0);
    // R10 / R5: enable bit 0 only, then its summary enable
    step("R10", '0, 1, 1, 32'h0000_0001, 0, '0);
    idle("R5", '0);
    step("R10", '0, 1, 1, 32'h0001_4845, 0, '0);
    idle("R8", '0);
    idle("R8", '0);
    // R7: writing a one to the normal summary bit does not clear it
    step("R7", '0, 1, 0, 32'h0001_0000, 0, '0);
    idle("R7", '0);
    // R5: a second normal event, then clear bit 0 only
    step("R5", 32'h0000_4000, 0, 0, '0, 0, '0);
    step("R3", '0, 1, 0, 32'h0000_0001, 0, '0);
    idle("R3", '0);
    // R4: set and clear on the same bit
    step("R4", 32'h0000_0040, 1, 0, 32'h0000_0040, 0, '0);
    idle("R4", '0);
    // R3: clear all normal events
    step("R3", '0, 1, 0, 32'hFFFF_FFFF, 0, 9'h155);
    idle("R8", 9'h155);
    idle("R8", 9'h0AA);
    // R6: abnormal events alone, mask enables event but not summary first
    step("R6", 32'h0C00_0080, 0, 0, '0, 0, 9'h0AA);
    step("R6", '0, 1, 1, 32'h0400_0080, 0, 9'h0AA);
    idle("R6", 9'h0AA);
    step("R7", '0, 1, 1, 32'h0400_8080, 0, 9'h0AA);
    idle("R8", 9'h0AA);
    idle("R8", 9'h1FF);
    // R7: mask change alone drops the summary
    step("R7", '0, 1, 1, 32'h0000_8000, 0, 9'h1FF);
    idle("R8", 9'h1FF);
    step("R6", 32'h0000_2000, 1, 1, 32'h0000_A000, 0, 9'h1FF);
    idle("R6", 9'h1FF);
    idle("R8", 9'h1FF);
    // R9: all-ones status write leaves state and reserved bits alone
    step("R9", '0, 1, 0, 32'hFFFF_FFFF, 0, 9'h123);
    idle("R9", 9'h123);
    // R11: soft reset beats set and write
    step("R6", 32'h0C00_7FFF, 1, 1, 32'hFFFF_FFFF, 0, '0);
    idle("R8", '0);
    step("R11", 32'h0C00_7FFF, 1, 1, 32'hFFFF_FFFF, 1, '0);
    idle("R11", '0);
    idle("R1", '0);
    @(negedge clk);
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule